// File: doc/BRIEF.md
# Decimal Adjust Flag Unit

This unit carries out the decimal and unpacked-decimal correction steps of an 8-bit accumulator datapath. It covers five operations:

- packed-decimal adjust after an add or a subtract;
- unpacked-decimal adjust after an add or a subtract;
- the base-conversion multiply-add, which folds the high accumulator byte into the low one through an arbitrary multiplier byte.

It takes the low and high accumulator bytes, the incoming half-carry and carry flags, a multiplier byte and an operation code. It returns the corrected bytes and all six arithmetic flags.

The flag rules follow one particular core rather than the textbook ones:

- The unpacked adjusts force Overflow low and Parity high. Their Sign flag is the inverse of the adjust condition.
- The packed adjusts can raise half-carry and carry but never lower them.
- The multiply-add takes every flag from its final 8-bit addition.

The arithmetic is purely combinational. The result is registered once, so every output appears one clock after its inputs. The unit is meant to sit beside the main ALU. Its outputs are picked up by the write-back path, which lies outside this block.

Top module: `decimal_adjust_unit`

## Requirements
- R1: Outputs are registered: a result appears on the outputs at the first rising clock edge after its inputs are applied. While rst_n is low, every output is 0.
- R2: op_i = 0 performs the packed add adjust. The low correction 0x06 applies when af_i is 1 or al_i[3:0] > 9. The high correction 0x60 applies when cf_i is 1 or al_i > 0x99, judged on the original al_i. al_o is al_i plus the correction, modulo 256. ah_o equals ah_i. OF, SF, ZF and PF are those of that addition (PF is 1 for an even count of ones).
- R3: op_i = 1 performs the packed subtract adjust. The conditions are the same as R2, both taken from the original al_i, with the al_i > 0x99 test deciding the high correction on its own. al_o is al_i minus the correction. ah_o equals ah_i. OF, SF, ZF and PF are those of that subtraction.
- R4: For op_i 0 and 1, af_o is 1 when the low correction applied or when the add/subtract carries or borrows out of bit 3. cf_o is 1 when the high correction applied or when the operation carries or borrows out of bit 7. Hence an incoming 1 on af_i or cf_i is never lost.
- R5: op_i = 2 (unpacked add adjust) and op_i = 3 (unpacked subtract adjust) use the adjust condition af_i = 1 or al_i[3:0] > 9. When the condition holds, al_o is the low nibble of al_i ± 6 and ah_o is ah_i ± 1 (plus for op 2, minus for op 3). Otherwise al_o is al_i[3:0] and ah_o is ah_i. al_o[7:4] is always 0.
- R6: For op_i 2 and 3, af_o, cf_o and zf_o all equal the adjust condition, sf_o is its inverse, of_o is 0 and pf_o is 1.
- R7: op_i = 4 computes al_o = (ah_i × imm_i + al_i) mod 256 and ah_o = 0.
- R8: For op_i = 4, all six flags are those of an 8-bit addition of (ah_i × imm_i) mod 256 and al_i: carry out of bit 7, carry out of bit 3, signed overflow, sign, zero and even parity.
- R9: op_i values 5, 6 and 7 pass al_i and ah_i through unchanged, copy af_i and cf_i to af_o and cf_o, and clear of_o, sf_o, zf_o and pf_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0..4 as in R2-R8, 5..7 pass-through) |
| al_i | input | 8 | Low accumulator byte |
| ah_i | input | 8 | High accumulator byte |
| imm_i | input | 8 | Multiplier byte for op 4 |
| af_i | input | 1 | Incoming half-carry flag |
| cf_i | input | 1 | Incoming carry flag |
| al_o | output | 8 | Adjusted low byte |
| ah_o | output | 8 | Adjusted high byte |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag (1 = even count of ones) |
| af_o | output | 1 | Half-carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |

## Verification
The hardest cases to reach are those in which a packed adjust sets half-carry or carry through the incoming flag alone. This happens when the nibble test and the 0x99 test are both false, yet the correction still carries or borrows across a bit boundary. An example is a subtract adjust of 0x00 with the incoming carry set, which wraps to 0xA0.

Random values rarely hit these alongside the 0x99/0x9A boundary. The bench therefore sweeps all 256 low-byte values against all four combinations of incoming half-carry and carry, for each of the four adjust operations. Random bytes and a few directed vectors then cover the multiply-add and the pass-through codes.

// File: rtl/dafu_pkg.sv
package dafu_pkg;

    localparam int W    = 8;
    localparam int NW   = W / 2;
    localparam int OPW  = 3;
    localparam int NINE = 9;

    localparam logic [OPW-1:0] OP_DAA = 3'd0;
    localparam logic [OPW-1:0] OP_DAS = 3'd1;
    localparam logic [OPW-1:0] OP_AAA = 3'd2;
    localparam logic [OPW-1:0] OP_AAS = 3'd3;
    localparam logic [OPW-1:0] OP_AAD = 3'd4;
    localparam logic [OPW-1:0] OP_IDLE = 3'd5;

    localparam logic [NW-1:0] NIB_SIX = NW'(6);
    localparam logic [W-1:0]  HI_LIMIT = W'(8'h99);

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic         cf;
        logic         pf;
        logic         af;
        logic         zf;
        logic         sf;
        logic         of;
    } adj_res_t;

    typedef struct packed {
        logic [OPW-1:0] op;
        logic           af_in;
        logic           cf_in;
        adj_res_t       r;
    } stage_t;

    function automatic logic even_par(input logic [W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/dafu_bcd_adj.sv
module dafu_bcd_adj
    import dafu_pkg::*;
(
    input  logic           sub_i,
    input  logic [W-1:0]   al_i,
    input  logic [W-1:0]   ah_i,
    input  logic           af_i,
    input  logic           cf_i,
    output adj_res_t       res_o
);
    logic          lo_fix;
    logic          hi_fix;
    logic [W-1:0]  corr;
    logic [W:0]    full;
    logic [NW:0]   half;
    logic [W-1:0]  r;

    always_comb begin
        lo_fix = af_i | (al_i[NW-1:0] > NW'(NINE));
        hi_fix = cf_i | (al_i > HI_LIMIT);
        corr   = {(hi_fix ? NIB_SIX : '0), (lo_fix ? NIB_SIX : '0)};
        if (sub_i) begin
            full = {1'b0, al_i} - {1'b0, corr};
            half = {1'b0, al_i[NW-1:0]} - {1'b0, corr[NW-1:0]};
        end else begin
            full = {1'b0, al_i} + {1'b0, corr};
            half = {1'b0, al_i[NW-1:0]} + {1'b0, corr[NW-1:0]};
        end
        r        = full[W-1:0];
        res_o.lo = r;
        res_o.hi = ah_i;
        res_o.cf = hi_fix | full[W];
        res_o.af = lo_fix | half[NW];
        res_o.of = sub_i ? (al_i[W-1] & ~r[W-1]) : (~al_i[W-1] & r[W-1]);
        res_o.sf = r[W-1];
        res_o.zf = (r == '0);
        res_o.pf = even_par(r);
    end
endmodule

// File: rtl/dafu_ascii_adj.sv
module dafu_ascii_adj
    import dafu_pkg::*;
(
    input  logic           sub_i,
    input  logic [W-1:0]   al_i,
    input  logic [W-1:0]   ah_i,
    input  logic           af_i,
    output adj_res_t       res_o
);
    logic          adj;
    logic [W-1:0]  lo_t;
    logic [W-1:0]  hi_t;

    always_comb begin
        adj  = af_i | (al_i[NW-1:0] > NW'(NINE));
        lo_t = sub_i ? (al_i - W'(6)) : (al_i + W'(6));
        hi_t = sub_i ? (ah_i - W'(1)) : (ah_i + W'(1));
        res_o.lo = {{(W-NW){1'b0}}, (adj ? lo_t[NW-1:0] : al_i[NW-1:0])};
        res_o.hi = adj ? hi_t : ah_i;
        res_o.cf = adj;
        res_o.af = adj;
        res_o.zf = adj;
        res_o.sf = ~adj;
        res_o.of = 1'b0;
        res_o.pf = 1'b1;
    end
endmodule

// File: rtl/dafu_mac.sv
module dafu_mac
    import dafu_pkg::*;
(
    input  logic [W-1:0]   al_i,
    input  logic [W-1:0]   ah_i,
    input  logic [W-1:0]   imm_i,
    output adj_res_t       res_o
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   p;
    logic [W:0]     sum;
    logic [NW:0]    half;
    logic [W-1:0]   r;

    always_comb begin
        prod = ah_i * imm_i;
        p    = prod[W-1:0];
        sum  = {1'b0, p} + {1'b0, al_i};
        half = {1'b0, p[NW-1:0]} + {1'b0, al_i[NW-1:0]};
        r    = sum[W-1:0];
        res_o.lo = r;
        res_o.hi = '0;
        res_o.cf = sum[W];
        res_o.af = half[NW];
        res_o.of = (p[W-1] == al_i[W-1]) && (r[W-1] != p[W-1]);
        res_o.sf = r[W-1];
        res_o.zf = (r == '0);
        res_o.pf = even_par(r);
    end
endmodule

// File: rtl/decimal_adjust_unit.sv
module decimal_adjust_unit
    import dafu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPW-1:0]      op_i,
    input  logic [W-1:0]        al_i,
    input  logic [W-1:0]        ah_i,
    input  logic [W-1:0]        imm_i,
    input  logic                af_i,
    input  logic                cf_i,
    output logic [W-1:0]        al_o,
    output logic [W-1:0]        ah_o,
    output logic                cf_o,
    output logic                pf_o,
    output logic                af_o,
    output logic                zf_o,
    output logic                sf_o,
    output logic                of_o
);
    adj_res_t bcd_res, asc_res, mac_res, idle_res;
    stage_t   stage_d, stage_q;

    dafu_bcd_adj u_bcd (
        .sub_i (op_i[0]),
        .al_i  (al_i),
        .ah_i  (ah_i),
        .af_i  (af_i),
        .cf_i  (cf_i),
        .res_o (bcd_res)
    );

    dafu_ascii_adj u_asc (
        .sub_i (op_i[0]),
        .al_i  (al_i),
        .ah_i  (ah_i),
        .af_i  (af_i),
        .res_o (asc_res)
    );

    dafu_mac u_mac (
        .al_i  (al_i),
        .ah_i  (ah_i),
        .imm_i (imm_i),
        .res_o (mac_res)
    );

    always_comb begin
        idle_res    = '0;
        idle_res.lo = al_i;
        idle_res.hi = ah_i;
        idle_res.af = af_i;
        idle_res.cf = cf_i;

        stage_d.op    = op_i;
        stage_d.af_in = af_i;
        stage_d.cf_in = cf_i;
        case (op_i)
            OP_DAA, OP_DAS: stage_d.r = bcd_res;
            OP_AAA, OP_AAS: stage_d.r = asc_res;
            OP_AAD:         stage_d.r = mac_res;
            default:        stage_d.r = idle_res;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q    <= '0;
            stage_q.op <= OP_IDLE;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign al_o = stage_q.r.lo;
    assign ah_o = stage_q.r.hi;
    assign cf_o = stage_q.r.cf;
    assign pf_o = stage_q.r.pf;
    assign af_o = stage_q.r.af;
    assign zf_o = stage_q.r.zf;
    assign sf_o = stage_q.r.sf;
    assign of_o = stage_q.r.of;
endmodule

// File: rtl/dafu_checker.sv
module dafu_checker
    import dafu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_q,
    input  logic           af_in_q,
    input  logic           cf_in_q,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   hi,
    input  logic           cf,
    input  logic           pf,
    input  logic           af,
    input  logic           zf,
    input  logic           sf,
    input  logic           of
);
    logic is_bcd, is_asc, is_mac, is_idle;
    assign is_bcd  = (op_q == OP_DAA) || (op_q == OP_DAS);
    assign is_asc  = (op_q == OP_AAA) || (op_q == OP_AAS);
    assign is_mac  = (op_q == OP_AAD);
    assign is_idle = !is_bcd && !is_asc && !is_mac;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (lo == '0 && hi == '0 && !cf && !af && !zf && !sf && !of && !pf));

    assert_keep_af_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bcd && af_in_q) |-> af);

    assert_keep_cf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bcd && cf_in_q) |-> cf);

    assert_high_nibble_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_asc |-> (lo[W-1:NW] == '0));

    assert_ascii_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_asc |-> (!of && pf && (sf == !cf) && (af == cf) && (zf == cf)));

    assert_mac_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_mac |-> (hi == '0));

    assert_sign_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mac || is_bcd) |-> ((sf == lo[W-1]) && (zf == (lo == '0))));

    assert_idle_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> (!of && !sf && !zf && !pf && (af == af_in_q) && (cf == cf_in_q)));
endmodule

bind decimal_adjust_unit dafu_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_q    (stage_q.op),
    .af_in_q (stage_q.af_in),
    .cf_in_q (stage_q.cf_in),
    .lo      (stage_q.r.lo),
    .hi      (stage_q.r.hi),
    .cf      (stage_q.r.cf),
    .pf      (stage_q.r.pf),
    .af      (stage_q.r.af),
    .zf      (stage_q.r.zf),
    .sf      (stage_q.r.sf),
    .of      (stage_q.r.of)
);

// File: tb/decimal_adjust_unit_test.sv
module decimal_adjust_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd5;
    logic [7:0] al_i = '0, ah_i = '0, imm_i = '0;
    logic       af_i = 1'b0, cf_i = 1'b0;
    logic [7:0] al_o, ah_o;
    logic       cf_o, pf_o, af_o, zf_o, sf_o, of_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    decimal_adjust_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .al_i(al_i), .ah_i(ah_i),
        .imm_i(imm_i), .af_i(af_i), .cf_i(cf_i), .al_o(al_o), .ah_o(ah_o),
        .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
    );

    // packing: {al, ah, cf, pf, af, zf, sf, of}
    function automatic logic [21:0] model(input int op, input int al, input int ah,
                                          input int imm, input bit af, input bit cf);
        int r, c, hc, h, p;
        bit ncf, naf, nof, cond, lo, hi;
        int nah;
        nah = ah; ncf = cf; naf = af; nof = 0;
        r = al;
        case (op)
            0, 1: begin
                lo = af || ((al % 16) > 9);
                hi = cf || (al > 153);
                c  = (lo ? 6 : 0) + (hi ? 96 : 0);
                if (op == 0) begin
                    r  = al + c;
                    hc = (al % 16) + (c % 16);
                    ncf = hi || (r > 255);
                    naf = lo || (hc > 15);
                    r  = r % 256;
                    nof = (al < 128) && (r >= 128);
                end else begin
                    r  = al - c;
                    hc = (al % 16) - (c % 16);
                    ncf = hi || (r < 0);
                    naf = lo || (hc < 0);
                    r  = (r + 256) % 256;
                    nof = (al >= 128) && (r < 128);
                end
            end
            2, 3: begin
                cond = af || ((al % 16) > 9);
                if (cond) begin
                    r   = (op == 2) ? al + 6 : al - 6 + 256;
                    nah = (op == 2) ? (ah + 1) % 256 : (ah + 255) % 256;
                end
                r = r % 16;
                return {r[7:0], nah[7:0], cond, 1'b1, cond, cond, !cond, 1'b0};
            end
            4: begin
                p   = (ah * imm) % 256;
                r   = p + al;
                ncf = r > 255;
                naf = ((p % 16) + (al % 16)) > 15;
                r   = r % 256;
                nof = ((p >= 128) == (al >= 128)) && ((r >= 128) != (p >= 128));
                nah = 0;
            end
            default: begin
                return {al[7:0], ah[7:0], cf, 1'b0, af, 1'b0, 1'b0, 1'b0};
            end
        endcase
        h = 0;
        for (int b = 0; b < 8; b++) h += (r >> b) & 1;
        return {r[7:0], nah[7:0], ncf, (h % 2 == 0), naf, (r == 0), (r >= 128), nof};
    endfunction

    function automatic string tag(input int op);
        case (op)
            0: return "R2/R4";
            1: return "R3/R4";
            2: return "R5/R6 (AAA)";
            3: return "R5/R6 (AAS)";
            4: return "R7/R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run(input int op, input int al, input int ah, input int imm,
                       input bit af, input bit cf);
        logic [21:0] exp, act;
        @(negedge clk);
        op_i = op[2:0]; al_i = al[7:0]; ah_i = ah[7:0]; imm_i = imm[7:0];
        af_i = af; cf_i = cf;
        @(negedge clk);
        exp = model(op, al, ah, imm, af, cf);
        act = {al_o, ah_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d al=%02h ah=%02h imm=%02h af=%0b cf=%0b actual=%06h expected=%06h",
                     tag(op), op, al, ah, imm, af, cf, act, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240807));
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if ({al_o, ah_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o} !== 22'd0) begin
            errors++;
            $display("FAIL R1 reset actual=%06h expected=000000",
                     {al_o, ah_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o});
        end
        rst_n = 1'b1;

        // Directed corners: R3 borrow via incoming carry, R2 0x99/0x9A boundary
        run(1, 8'h00, 8'h12, 0, 0, 1);
        run(1, 8'h9A, 8'h00, 0, 0, 0);
        run(0, 8'h99, 8'h00, 0, 0, 0);
        run(0, 8'h9A, 8'h00, 0, 0, 0);
        run(2, 8'h0F, 8'hFF, 0, 0, 0);
        run(3, 8'h00, 8'h00, 0, 1, 0);
        run(4, 8'h07, 8'h09, 10, 0, 0);
        run(4, 8'h80, 8'h10, 8, 1, 1);

        // R2-R6: full low-byte sweep for each adjust op and flag combination
        for (int op = 0; op < 4; op++)
            for (int fl = 0; fl < 4; fl++)
                for (int a = 0; a < 256; a++)
                    run(op, a, $urandom % 256, $urandom % 256, fl[0], fl[1]);

        // R7/R8: random multiply-add
        for (int k = 0; k < 600; k++)
            run(4, $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);

        // R9: idle codes
        for (int k = 0; k < 60; k++)
            run(5 + (k % 3), $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);

        // R1: one-cycle latency, output holds the previous result until the next edge
        @(negedge clk);
        op_i = 3'd5; al_i = 8'h3C; ah_i = 8'hA5; af_i = 1'b0; cf_i = 1'b0;
        @(posedge clk);
        #1;
        checks++;
        if (al_o !== 8'h3C) begin
            errors++;
            $display("FAIL R1 latency actual=%02h expected=3c", al_o);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule